// File: doc/BRIEF.md
# Odd-Ratio Half-Duty Clock Divider

The block divides an input clock by a fixed odd ratio N (default 3) and delivers an output clock whose high and low phases are each exactly N half periods of the input clock. A single modulo-N counter on the rising edge steers two toggle flops. One toggles on a rising edge when the count is zero. The other toggles on a falling edge when the count sits at the midpoint value (N+1)/2. The exclusive-OR of the two flops is the divided clock. A single flop on one edge can only produce phases that are a whole number of input cycles long. An odd ratio therefore needs the falling-edge flop to reach an even split.

A single active-high enable acts as a synchronous reset. While it is low, the counter and both toggle flops are cleared and the output stays low. When it is raised, the output goes high on the first rising edge that samples it high. The ratio is fixed at elaboration. An even ratio or a ratio below 3 stops elaboration with an error.

Top module: `odd_clk_div`

## Requirements
- R1: While the enable is sampled low, the output is 0 from the first rising edge that samples it low until the enable is sampled high again.
- R2: The internal count steps 0, 1, ..., N-1 on rising edges and then wraps to 0, so the output repeats every N input cycles.
- R3: After the enable rises, the output stays 0 until the first rising edge that samples the enable high, and goes to 1 at that edge.
- R4: The rising-edge toggle flop changes only at a rising edge where the count is 0, so every rising transition of the output is aligned to a rising input edge.
- R5: The falling-edge toggle flop changes only at a falling edge where the count equals (N+1)/2, so every falling transition of the output is aligned to a falling input edge.
- R6: Every high phase of the output lasts exactly N half periods of the input clock.
- R7: Every low phase of the output lasts exactly N half periods of the input clock.
- R8: Successive rising transitions of the output are exactly 2N half periods (N input cycles) apart.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Input clock to be divided |
| en_i | input | 1 | Active-high enable; low clears the divider synchronously |
| clk_o | output | 1 | Divided clock, period N input cycles, half duty |

## Verification
On every edge the assertions check the counter range and its step, that each toggle flop changes only at its own decode and always changes there, and that the counter and flops are cleared whenever the enable is low. The exact phase lengths, the period, the edge on which each output transition lands and the start-up timing after enable all depend on how the two clock edges interleave. Only the bench's scenarios can show these. It samples every half period at ratios 3, 5 and 7 and switches the enable off at many different counter phases.

// File: rtl/odd_clk_div.sv
module odd_clk_div #(
  parameter int N = 3
) (
  input  logic clk_i,
  input  logic en_i,
  output logic clk_o
);

  localparam int W = (N > 1) ? $clog2(N) : 1;
  localparam logic [W-1:0] LAST = W'(N - 1);
  localparam logic [W-1:0] MID  = W'((N + 1) / 2);

  if ((N < 3) || ((N % 2) == 0)) begin : g_bad_ratio
    $error("odd_clk_div: N must be odd and at least 3");
  end

  logic [W-1:0] cnt_q;
  logic         rise_q;
  logic         fall_q;

  always_ff @(posedge clk_i) begin
    if (!en_i)              cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + W'(1);
  end

  always_ff @(posedge clk_i) begin
    if (!en_i)              rise_q <= 1'b0;
    else if (cnt_q == '0)   rise_q <= ~rise_q;
  end

  always_ff @(negedge clk_i) begin
    if (!en_i)              fall_q <= 1'b0;
    else if (cnt_q == MID)  fall_q <= ~fall_q;
  end

  assign clk_o = rise_q ^ fall_q;

endmodule

// File: rtl/odd_clk_div_chk.sv
module odd_clk_div_chk #(
  parameter int N = 3
) (
  input logic                                  clk_i,
  input logic                                  en_i,
  input logic [((N > 1) ? $clog2(N) : 1)-1:0]  cnt_q,
  input logic                                  rise_q,
  input logic                                  fall_q
);

  localparam int W = (N > 1) ? $clog2(N) : 1;
  localparam logic [W-1:0] LAST = W'(N - 1);
  localparam logic [W-1:0] MID  = W'((N + 1) / 2);

  AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!en_i)
    cnt_q <= LAST);  // R2

  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!en_i)
    (cnt_q != LAST) |=> (cnt_q == $past(cnt_q) + W'(1)));  // R2

  AST_CNT_WRAP: assert property (@(posedge clk_i) disable iff (!en_i)
    (cnt_q == LAST) |=> (cnt_q == '0));  // R2

  AST_RISE_HOLD: assert property (@(posedge clk_i) disable iff (!en_i)
    (cnt_q != '0) |=> $stable(rise_q));  // R4

  AST_RISE_FLIP: assert property (@(posedge clk_i) disable iff (!en_i)
    (cnt_q == '0) |=> (rise_q != $past(rise_q)));  // R4

  AST_FALL_HOLD: assert property (@(negedge clk_i) disable iff (!en_i)
    (cnt_q != MID) |=> $stable(fall_q));  // R5

  AST_FALL_FLIP: assert property (@(negedge clk_i) disable iff (!en_i)
    (cnt_q == MID) |=> (fall_q != $past(fall_q)));  // R5

  AST_IDLE_RISE: assert property (@(posedge clk_i) disable iff (en_i)
    !en_i |=> (!rise_q && (cnt_q == '0)));  // R1

  AST_IDLE_FALL: assert property (@(negedge clk_i) disable iff (en_i)
    !en_i |=> !fall_q);  // R1

endmodule

bind odd_clk_div odd_clk_div_chk #(.N(N)) i_chk (
  .clk_i  (clk_i),
  .en_i   (en_i),
  .cnt_q  (cnt_q),
  .rise_q (rise_q),
  .fall_q (fall_q)
);

// File: tb/test_odd_clk_div.sv
module test_odd_clk_div;

  logic clk = 1'b0;
  logic en  = 1'b0;
  logic c3, c5, c7;
  int   checks = 0;
  int   fails  = 0;

  always #10 clk = ~clk;

  odd_clk_div #(.N(3)) i_odd_clk_div    (.clk_i(clk), .en_i(en), .clk_o(c3));
  odd_clk_div #(.N(5)) i_odd_clk_div_n5 (.clk_i(clk), .en_i(en), .clk_o(c5));
  odd_clk_div #(.N(7)) i_odd_clk_div_n7 (.clk_i(clk), .en_i(en), .clk_o(c7));

  function automatic int ratio(int d);
    return 3 + 2 * d;
  endfunction

  function automatic int outv(int d);
    case (d)
      0:       return int'(c3);
      1:       return int'(c5);
      default: return int'(c7);
    endcase
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic all_low(string req);
    for (int d = 0; d < 3; d++)
      chk($sformatf("%s N=%0d output low", req, ratio(d)), outv(d), 0);
  endtask

  // Called at rising edge + 5 ns with enable low; returns at the same phase.
  task automatic run_enabled(int cycles);
    int prev [3];
    int run  [3];
    int rise [3];
    en = 1'b1;
    #10;
    all_low("R3 before first edge");
    #10;
    for (int d = 0; d < 3; d++) begin
      chk($sformatf("R3 N=%0d high at first edge", ratio(d)), outv(d), 1);
      prev[d] = 1; run[d] = 1; rise[d] = 2;
    end
    for (int idx = 3; idx <= 2 * cycles; idx++) begin
      #10;
      for (int d = 0; d < 3; d++) begin
        int v;
        v = outv(d);
        if (v == prev[d]) run[d]++;
        else begin
          if (v == 1) begin
            chk($sformatf("R7 N=%0d low half-cycles", ratio(d)), run[d], ratio(d));
            chk($sformatf("R4 N=%0d rise on rising phase", ratio(d)), idx % 2, 0);
            chk($sformatf("R2 R8 N=%0d rise spacing", ratio(d)), idx - rise[d], 2 * ratio(d));
            rise[d] = idx;
          end else begin
            chk($sformatf("R6 N=%0d high half-cycles", ratio(d)), run[d], ratio(d));
            chk($sformatf("R5 N=%0d fall on falling phase", ratio(d)), idx % 2, 1);
          end
          run[d]  = 1;
          prev[d] = v;
        end
      end
    end
  endtask

  task automatic run_disabled(int cycles);
    en = 1'b0;
    #20;
    all_low("R1 after disable");
    for (int i = 0; i < 2 * cycles; i++) begin
      #10;
      all_low("R1 held");
    end
  endtask

  initial begin
    #15;
    for (int i = 0; i < 6; i++) begin
      #10;
      all_low("R1 reset state");
    end
    run_enabled(40);
    run_disabled(4);
    for (int k = 0; k < 24; k++) begin
      run_enabled(4 + k);
      run_disabled(1 + (k % 3));
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #4000000;
    fails++;
    $display("FAIL watchdog R1 R8 actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule